// File: doc/BRIEF.md
# Boot Window Address Remapper

This unit sits between the CPU's fetch/read address bus and the code memory. It lets software redirect the 4 KB boot window at the bottom of segment 0 to another 4 KB region of segment 0. The boot window holds the reset vector and the interrupt vectors, so a redirected window gives a separate program its own vectors. Software writes the upper nibble of the target start address into a special-function register. The new mapping is not applied at once. It is copied into an active shadow register only on a CPU-only soft reset, so code and vectors switch on the same edge.

The original boot area stays readable through an alias window in segment 8. The flash programming address path is never translated. A target whose 4 KB region would reach into the reserved test area at the top of segment 0 is rejected at soft reset, and the previous mapping remains in force. Translation is purely combinational.

The active mapping is kept as a two-state machine, `MAP_DIRECT` (identity) and `MAP_REDIRECT` (window redirected). On each soft reset with a valid pending value, the machine takes one of four transitions:
- ENGAGE: `MAP_DIRECT` to `MAP_REDIRECT`, taken when the pending value is non-zero.
- RETARGET: `MAP_REDIRECT` to `MAP_REDIRECT` with a new shadow value.
- RELEASE: `MAP_REDIRECT` to `MAP_DIRECT`, taken when the pending value is zero.
- RETAIN: the state and shadow are left unchanged. This happens on an invalid pending value, or when no soft reset occurs.

A full reset forces `MAP_DIRECT`.

Top module: `boot_remap`

## Requirements
- R1: After full reset (`rst_n` low), every CPU address passes to `phys_addr` unchanged.
- R2: A write with `sfr_we` high and `sfr_addr` equal to F0ECH loads `sfr_wdata[3:0]` into the pending register; upper data bits and writes to any other address are ignored.
- R3: A pending-register write does not alter the translation until the next `cpu_soft_rst` clock edge.
- R4: On the clock edge where `cpu_soft_rst` is high and the pending value N is valid, the active mapping becomes N. From then on, a CPU address 0:xxxx with xxxx in 0000H..0FFFH maps to 0:(N·1000H + xxxx), which includes the vector locations at the bottom of the window.
- R5: CPU addresses outside the segment-0 window and outside the segment-8 alias pass through unchanged, including addresses inside the target region itself.
- R6: A CPU address 8:xxxx with xxxx in 0000H..0FFFH maps to physical 0:xxxx, whatever the active mapping.
- R7: `flash_addr_out` always equals `flash_addr_in`.
- R8: A pending value N for which N·1000H+0FFFH ≥ FC00H (the test area) is ignored at soft reset, and the previous mapping is kept. N = 0EH is still accepted.
- R9: Full reset clears both the pending and the active value. A soft reset with pending value 0 restores the identity mapping.
- R10: A soft reset does not clear the pending register, so a later soft reset re-applies the same value.
- R11: `phys_addr` follows `cpu_addr` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full system reset, active low |
| cpu_soft_rst | input | 1 | CPU-only reset strobe; loads the active mapping |
| sfr_we | input | 1 | Special-function register write enable |
| sfr_addr | input | 16 | Special-function register address |
| sfr_wdata | input | 8 | Special-function register write data |
| cpu_addr | input | 20 | CPU fetch/read address {segment[3:0], offset[15:0]} |
| phys_addr | output | 20 | Translated physical address |
| flash_addr_in | input | 20 | Flash programming address |
| flash_addr_out | output | 20 | Untranslated flash programming address |

## Verification
The bench builds the block with its default parameters: a 4 KB window, a 4-bit target nibble, alias segment 8, and the test area at FC00H. With these values only nibble 0FH overlaps the test area, so the rejected value and the last accepted value (0EH) are adjacent and both are driven. A 4-bit segment field lets random addresses fall often into segment 0, segment 8 and other segments, so window, alias and pass-through cases all occur against a behavioural model.

// File: rtl/bremap_pkg.sv
package bremap_pkg;
    typedef enum logic [0:0] {
        MAP_DIRECT   = 1'b0,
        MAP_REDIRECT = 1'b1
    } map_state_e;
endpackage

// File: rtl/bremap_sfr.sv
module bremap_sfr #(
    parameter int SFR_AW   = 16,
    parameter int DATA_W   = 8,
    parameter int NIB_W    = 4,
    parameter logic [SFR_AW-1:0] SFR_LOC = 16'hF0EC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [NIB_W-1:0]  pending
);
    logic hit;

    always_comb begin
        hit = sfr_we && (sfr_addr == SFR_LOC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (hit) begin
            pending <= sfr_wdata[NIB_W-1:0];
        end
    end

    // R2: a write to any other address leaves the pending value alone
    a_r2_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && sfr_addr == SFR_LOC) |=> $stable(pending));
endmodule

// File: rtl/bremap_fsm.sv
module bremap_fsm
    import bremap_pkg::*;
#(
    parameter int OFS_W    = 16,
    parameter int WIN_BITS = 12,
    parameter int NIB_W    = OFS_W - WIN_BITS,
    parameter logic [OFS_W-1:0] TEST_BASE = 16'hFC00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_soft_rst,
    input  logic [NIB_W-1:0] pending,
    output map_state_e       state,
    output logic [NIB_W-1:0] shadow
);
    logic [OFS_W:0]   pend_last;
    logic             pend_ok;
    map_state_e       state_nx;
    logic [NIB_W-1:0] shadow_nx;

    // last byte of the candidate region must stay below the test area
    always_comb begin
        pend_last = {1'b0, pending, {WIN_BITS{1'b1}}};
        pend_ok   = pend_last < {1'b0, TEST_BASE};
    end

    always_comb begin
        state_nx  = state;
        shadow_nx = shadow;
        if (cpu_soft_rst && pend_ok) begin
            unique case (state)
                MAP_DIRECT: begin
                    if (pending != '0) begin      // ENGAGE
                        state_nx  = MAP_REDIRECT;
                        shadow_nx = pending;
                    end
                end
                MAP_REDIRECT: begin
                    if (pending == '0) begin      // RELEASE
                        state_nx  = MAP_DIRECT;
                        shadow_nx = '0;
                    end else begin                // RETARGET
                        shadow_nx = pending;
                    end
                end
                default: begin
                    state_nx  = MAP_DIRECT;
                    shadow_nx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= MAP_DIRECT;
            shadow <= '0;
        end else begin
            state  <= state_nx;
            shadow <= shadow_nx;
        end
    end

    // R3: no soft reset, no change of the active mapping
    a_r3_hold_mapping: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_soft_rst |=> $stable(shadow) && $stable(state));
    // R8: a target touching the test area is refused
    a_r8_reject_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_soft_rst && !pend_ok) |=> $stable(shadow));
    // R4: an accepted value becomes the active one
    a_r4_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_soft_rst && pend_ok) |=> shadow == $past(pending));
    // R9: identity state means a zero shadow
    a_r9_direct_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MAP_DIRECT) |-> (shadow == '0));
endmodule

// File: rtl/bremap_xlate.sv
module bremap_xlate
    import bremap_pkg::*;
#(
    parameter int SEG_W     = 4,
    parameter int OFS_W     = 16,
    parameter int WIN_BITS  = 12,
    parameter int NIB_W     = OFS_W - WIN_BITS,
    parameter int ALIAS_SEG = 8,
    parameter logic [OFS_W-1:0] TEST_BASE = 16'hFC00,
    localparam int ADDR_W   = SEG_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  map_state_e        state,
    input  logic [NIB_W-1:0]  shadow,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    logic [SEG_W-1:0] seg;
    logic [OFS_W-1:0] ofs;
    logic             in_win;
    logic             seg_zero;
    logic             seg_alias;

    always_comb begin
        seg       = cpu_addr[ADDR_W-1:OFS_W];
        ofs       = cpu_addr[OFS_W-1:0];
        in_win    = (ofs[OFS_W-1:WIN_BITS] == '0);
        seg_zero  = (seg == '0);
        seg_alias = (seg == SEG_W'(ALIAS_SEG));
    end

    always_comb begin
        phys_addr = cpu_addr;
        if (in_win && seg_zero && state == MAP_REDIRECT) begin
            phys_addr = {{SEG_W{1'b0}}, shadow, ofs[WIN_BITS-1:0]};
        end else if (in_win && seg_alias) begin
            phys_addr = {{SEG_W{1'b0}}, ofs};
        end
    end

    // R8: boot-window fetches never land in the test area
    a_r8_never_test: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_zero && in_win) |-> (phys_addr[OFS_W-1:0] < TEST_BASE));
endmodule

// File: rtl/boot_remap.sv
module boot_remap
    import bremap_pkg::*;
#(
    parameter int SEG_W     = 4,
    parameter int OFS_W     = 16,
    parameter int WIN_BITS  = 12,
    parameter int SFR_AW    = 16,
    parameter int DATA_W    = 8,
    parameter int ALIAS_SEG = 8,
    parameter logic [SFR_AW-1:0] SFR_LOC   = 16'hF0EC,
    parameter logic [OFS_W-1:0]  TEST_BASE = 16'hFC00,
    localparam int ADDR_W   = SEG_W + OFS_W,
    localparam int NIB_W    = OFS_W - WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_soft_rst,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] phys_addr,
    input  logic [ADDR_W-1:0] flash_addr_in,
    output logic [ADDR_W-1:0] flash_addr_out
);
    logic [NIB_W-1:0] pending;
    logic [NIB_W-1:0] shadow;
    map_state_e       state;

    bremap_sfr #(
        .SFR_AW (SFR_AW),
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W),
        .SFR_LOC(SFR_LOC)
    ) u_sfr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sfr_we   (sfr_we),
        .sfr_addr (sfr_addr),
        .sfr_wdata(sfr_wdata),
        .pending  (pending)
    );

    bremap_fsm #(
        .OFS_W    (OFS_W),
        .WIN_BITS (WIN_BITS),
        .NIB_W    (NIB_W),
        .TEST_BASE(TEST_BASE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_soft_rst(cpu_soft_rst),
        .pending     (pending),
        .state       (state),
        .shadow      (shadow)
    );

    bremap_xlate #(
        .SEG_W    (SEG_W),
        .OFS_W    (OFS_W),
        .WIN_BITS (WIN_BITS),
        .NIB_W    (NIB_W),
        .ALIAS_SEG(ALIAS_SEG),
        .TEST_BASE(TEST_BASE)
    ) u_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .shadow   (shadow),
        .cpu_addr (cpu_addr),
        .phys_addr(phys_addr)
    );

    // R7: programming addresses bypass translation
    always_comb begin
        flash_addr_out = flash_addr_in;
    end
endmodule

// File: tb/tb_boot_remap.sv
`timescale 1ns/1ps
module tb_boot_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_soft_rst = 1'b0;
    logic        sfr_we = 1'b0;
    logic [15:0] sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic [19:0] cpu_addr = '0;
    logic [19:0] phys_addr;
    logic [19:0] flash_addr_in = '0;
    logic [19:0] flash_addr_out;

    int vectors = 0;
    int miscompares = 0;
    int m_pending = 0;
    int m_active = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boot_remap dut (
        .clk(clk), .rst_n(rst_n), .cpu_soft_rst(cpu_soft_rst),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .flash_addr_in(flash_addr_in), .flash_addr_out(flash_addr_out)
    );

    function automatic logic [19:0] exp_phys(input logic [19:0] a);
        int seg = int'(a[19:16]);
        int ofs = int'(a[15:0]);
        if (seg == 0 && ofs < 4096) return 20'((m_active * 4096) + ofs);
        if (seg == 8 && ofs < 4096) return 20'(ofs);
        return a;
    endfunction

    // drive one cycle, compare the combinational outputs, then advance the model
    task automatic step(input string tag, input logic [19:0] a, input logic [19:0] fa,
                        input logic we, input logic [15:0] wa, input logic [7:0] wd,
                        input logic srst);
        logic [19:0] e;
        cpu_addr = a; flash_addr_in = fa;
        sfr_we = we; sfr_addr = wa; sfr_wdata = wd; cpu_soft_rst = srst;
        #1;
        e = exp_phys(a);
        vectors++;
        if (phys_addr !== e) begin
            miscompares++;
            $display("FAIL %s phys addr=%05h actual=%05h expected=%05h", tag, a, phys_addr, e);
        end
        vectors++;
        if (flash_addr_out !== fa) begin
            miscompares++;
            $display("FAIL R7 flash actual=%05h expected=%05h", flash_addr_out, fa);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_pending = 0; m_active = 0;
        end else begin
            if (srst && (m_pending * 4096 + 4095) < 'hFC00) m_active = m_pending;
            if (we && wa == 16'hF0EC) m_pending = int'(wd[3:0]);
        end
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input logic [15:0] wa, input logic [7:0] wd);
        step(tag, 20'h0_0000, 20'h1_2345, 1'b1, wa, wd, 1'b0);
    endtask

    task automatic srst(input string tag);
        step(tag, 20'h0_0000, 20'h0_0000, 1'b0, 16'h0, 8'h0, 1'b1);
    endtask

    task automatic rd(input string tag, input logic [19:0] a);
        step(tag, a, a ^ 20'hA_5A5A, 1'b0, 16'h0, 8'h0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        rd("R1", 20'h0_0123);
        rd("R1", 20'h0_0FFF);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1", 20'h0_0000);
        rd("R1", 20'h0_0ABC);

        // R2 / R3: write 3 with noise in upper bits, mapping must not move yet
        wr("R2", 16'hF0EC, 8'hA3);
        rd("R3", 20'h0_0000);
        rd("R3", 20'h0_0FFF);
        // R4: soft reset engages; vectors at window bottom follow
        srst("R4");
        rd("R4", 20'h0_0000);
        rd("R4", 20'h0_0004);
        rd("R4", 20'h0_0FFF);
        // R5: pass-through outside the window, including the target itself
        rd("R5", 20'h0_1000);
        rd("R5", 20'h0_3000);
        rd("R5", 20'h1_0000);
        rd("R5", 20'hF_0ABC);
        // R6: alias window
        rd("R6", 20'h8_0000);
        rd("R6", 20'h8_0FFF);
        rd("R5", 20'h8_1000);
        // R7: flash path
        step("R7", 20'h0_0010, 20'h0_0010, 1'b0, 16'h0, 8'h0, 1'b0);
        // R2: foreign address ignored
        wr("R2", 16'hF0ED, 8'h05);
        srst("R2");
        rd("R2", 20'h0_0100);
        // R8: 0F rejected, 0E accepted
        wr("R8", 16'hF0EC, 8'h0F);
        srst("R8");
        rd("R8", 20'h0_0200);
        wr("R8", 16'hF0EC, 8'h0E);
        srst("R8");
        rd("R8", 20'h0_0FFF);
        // R10: second soft reset re-applies the kept value
        srst("R10");
        rd("R10", 20'h0_0040);
        // R9: pending zero restores identity
        wr("R9", 16'hF0EC, 8'h00);
        srst("R9");
        rd("R9", 20'h0_0040);
        // R9: full reset clears pending too
        wr("R9", 16'hF0EC, 8'h05);
        rst_n = 1'b0;
        rd("R9", 20'h0_0040);
        rst_n = 1'b1;
        @(negedge clk);
        srst("R9");
        rd("R9", 20'h0_0040);

        // R11: random traffic, same-cycle comparison against the model
        for (int i = 0; i < 600; i++) begin
            logic [19:0] a;
            logic [3:0]  sg;
            int          pick;
            pick = $urandom_range(0, 3);
            sg = (pick == 0) ? 4'h0 : (pick == 1) ? 4'h8 : 4'($urandom_range(0, 15));
            a = {sg, 16'($urandom_range(0, 'h1FFF) | (($urandom_range(0, 7) == 0) ? 'hE000 : 0))};
            step("R11", a, 20'($urandom),
                 ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 3) == 0) ? 16'hF0ED : 16'hF0EC,
                 8'($urandom),
                 ($urandom_range(0, 7) == 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule